// File: doc/BRIEF.md
# External Bus Recovery-Cycle Inserter

This block sits between the bus masters and an external bus sequencer. It decides when the next external access may start. Each access is a request with a chip-select channel, a read/write flag and an SDRAM flag. The block may hold a request back so that dead cycles follow a read. A slow device that is still driving the data lines after a read then releases them before another device, or the controller itself, drives them.

Each channel has a small recovery register. Software can change it only while that channel is switched off. The number of dead cycles comes from the register of the channel that did the preceding read. Bus cycles in which nothing was granted count toward that number. Accesses that involve SDRAM never wait.

The request side is valid/ready. A master raises `req_valid` with stable attributes and must hold them until a cycle in which `req_ready` is high; the access is granted at that rising edge. `req_ready` does not depend on `req_valid`. The block adds no buffering, so back-pressure reaches the master directly.

Top module: `bus_recov_gate`

## Requirements
- R1: After reset every channel's recovery field reads back as 0, and register bits above the 4-bit field always read back as 0.
- R2: A configuration write to a disabled channel stores bits [3:0] of the write data as that channel's recovery count (0 to 15 cycles, linear); the upper write bits are discarded.
- R3: A configuration write to a channel whose enable bit is 1 is ignored; the stored count is unchanged.
- R4: A read followed by a write waits N recovery cycles, where N is the count, even when both use the same channel.
- R5: A read followed by a read on a different channel waits N recovery cycles.
- R6: A read followed by a read on the same channel gets no recovery cycles.
- R7: When the preceding granted access was a write, or nothing has been granted since reset, the next request is never held.
- R8: When the preceding read or the new request targets SDRAM (`req_sdram`=1 on either), no recovery cycles are inserted, whatever the count.
- R9: Cycles without a grant since the preceding access are credited: with k such cycles before the request appears, it is held for max(N-k, 0) cycles. The credit counter saturates and never wraps.
- R10: N is taken from the channel that performed the preceding read, not from the requesting channel.
- R11: `req_ready` rises in the cycle the remaining count reaches zero. With nothing left to wait, the grant happens in the same cycle the request appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_waddr | input | 2 | Channel written |
| cfg_wdata | input | 16 | Write data; bits [3:0] hold the count |
| cfg_raddr | input | 2 | Channel read back |
| cfg_rdata | output | 16 | Readback; upper bits zero |
| ch_en | input | 4 | Per-channel enable; blocks configuration writes |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Access may start this cycle |
| req_ch | input | 2 | Chip-select channel of the request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_sdram | input | 1 | Request targets SDRAM |

## Verification
Two functions can fall in the same cycle: crediting idle cycles and reaching the grant. When the gap already covers the count, the request must be granted in the very cycle it appears. The bench provokes this by sweeping every count from 0 to 15 against idle gaps of 0 to 16 cycles, for each access-pair case. It compares the number of held cycles with max(N-k, 0), so k = N, k > N and the saturated counter are all hit. A second programmed channel carries a different count, so a grant timed from the wrong channel's count is caught.

// File: rtl/bus_recov_pkg.sv
package bus_recov_pkg;

  typedef enum logic {
    ACC_WR = 1'b0,
    ACC_RD = 1'b1
  } acc_kind_e;

  // Attributes of the most recently granted access, channel kept apart
  typedef struct packed {
    logic      seen;   // an access has been granted since reset
    acc_kind_e kind;
    logic      sdram;
  } hist_flags_t;

endpackage

// File: rtl/recov_regfile.sv
module recov_regfile #(
  parameter int NCH   = 4,
  parameter int CNT_W = 4,
  parameter int REG_W = 16,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [CH_W-1:0]        cfg_waddr,
  input  logic [REG_W-1:0]       cfg_wdata,
  input  logic [NCH-1:0]         ch_en,
  input  logic [CH_W-1:0]        cfg_raddr,
  output logic [REG_W-1:0]       cfg_rdata,
  output logic [NCH*CNT_W-1:0]   cnt_flat
);

  logic [CNT_W-1:0] field_q [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [CH_W-1:0] IDX = CH_W'(i);
    logic hit;
    assign hit = cfg_we && (cfg_waddr == IDX) && !ch_en[i];

    always_ff @(posedge clk) begin
      if (!rst_n)   field_q[i] <= '0;
      else if (hit) field_q[i] <= cfg_wdata[CNT_W-1:0];
    end

    assign cnt_flat[i*CNT_W +: CNT_W] = field_q[i];

    // R3: writes to an enabled channel leave it untouched
    a_r3_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_waddr == IDX && ch_en[i]) |=> (field_q[i] == $past(field_q[i])));

    // R2: an open channel takes the low bits of the write data
    a_r2_open_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_waddr == IDX && !ch_en[i]) |=> (field_q[i] == $past(cfg_wdata[CNT_W-1:0])));
  end

  always_comb begin
    cfg_rdata = '0;
    cfg_rdata[CNT_W-1:0] = field_q[cfg_raddr];
  end

endmodule

// File: rtl/recov_history.sv
module recov_history
  import bus_recov_pkg::*;
#(
  parameter int CH_W  = 2,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant,
  input  logic [CH_W-1:0]  acc_ch,
  input  acc_kind_e        acc_kind,
  input  logic             acc_sdram,
  output hist_flags_t      hist,
  output logic [CH_W-1:0]  hist_ch,
  output logic [CNT_W-1:0] idle_cnt
);

  localparam logic [CNT_W-1:0] IDLE_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist     <= '{seen: 1'b0, kind: ACC_WR, sdram: 1'b0};
      hist_ch  <= '0;
      idle_cnt <= '0;
    end else if (grant) begin
      hist     <= '{seen: 1'b1, kind: acc_kind, sdram: acc_sdram};
      hist_ch  <= acc_ch;
      idle_cnt <= '0;
    end else if (idle_cnt != IDLE_MAX) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  // R9: credit restarts after every grant
  a_r9_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> (idle_cnt == '0));

  // R9: credit saturates instead of wrapping
  a_r9_idle_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant && idle_cnt == IDLE_MAX) |=> (idle_cnt == IDLE_MAX));

endmodule

// File: rtl/recov_decide.sv
module recov_decide
  import bus_recov_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 4,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH*CNT_W-1:0] cnt_flat,
  input  hist_flags_t          hist,
  input  logic [CH_W-1:0]      hist_ch,
  input  logic [CNT_W-1:0]     idle_cnt,
  input  logic [CH_W-1:0]      req_ch,
  input  acc_kind_e            req_kind,
  input  logic                 req_sdram,
  output logic                 ready
);

  logic [CNT_W-1:0] prev_cnt;
  logic             needs_recov;
  logic [CNT_W-1:0] need;

  always_comb begin
    prev_cnt    = cnt_flat[hist_ch*CNT_W +: CNT_W];
    needs_recov = hist.seen && (hist.kind == ACC_RD) && !hist.sdram && !req_sdram &&
                  ((req_kind == ACC_WR) || (req_ch != hist_ch));
    need        = needs_recov ? prev_cnt : '0;
    ready       = (idle_cnt >= need);
  end

  // R6: same-channel back-to-back reads are never held
  a_r6_same_read: assert property (@(posedge clk) disable iff (!rst_n)
    (hist.kind == ACC_RD && req_kind == ACC_RD && req_ch == hist_ch) |-> ready);

  // R7: no post-read recovery after a write
  a_r7_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (hist.kind == ACC_WR) |-> ready);

  // R8: SDRAM on either side never waits
  a_r8_sdram_free: assert property (@(posedge clk) disable iff (!rst_n)
    (req_sdram || hist.sdram) |-> ready);

endmodule

// File: rtl/bus_recov_gate.sv
module bus_recov_gate
  import bus_recov_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 4,
  parameter int REG_W = 16,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CH_W-1:0]  cfg_waddr,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic [CH_W-1:0]  cfg_raddr,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic [NCH-1:0]   ch_en,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CH_W-1:0]  req_ch,
  input  logic             req_wr,
  input  logic             req_sdram
);

  logic [NCH*CNT_W-1:0] cnt_flat;
  hist_flags_t          hist;
  logic [CH_W-1:0]      hist_ch;
  logic [CNT_W-1:0]     idle_cnt;
  acc_kind_e            req_kind;
  logic                 grant;

  assign req_kind = req_wr ? ACC_WR : ACC_RD;
  assign grant    = req_valid && req_ready;

  recov_regfile #(.NCH(NCH), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .ch_en(ch_en), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .cnt_flat(cnt_flat)
  );

  recov_history #(.CH_W(CH_W), .CNT_W(CNT_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .grant(grant),
    .acc_ch(req_ch), .acc_kind(req_kind), .acc_sdram(req_sdram),
    .hist(hist), .hist_ch(hist_ch), .idle_cnt(idle_cnt)
  );

  recov_decide #(.NCH(NCH), .CNT_W(CNT_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cnt_flat(cnt_flat),
    .hist(hist), .hist_ch(hist_ch), .idle_cnt(idle_cnt),
    .req_ch(req_ch), .req_kind(req_kind), .req_sdram(req_sdram),
    .ready(req_ready)
  );

  // R11: a held request becomes grantable only as credit grows; once
  // ready with no grant and unchanged attributes, it stays ready
  a_r11_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid && $stable(req_ch) && $stable(req_wr) && $stable(req_sdram))
    |=> (req_ready || $changed(req_ch) || $changed(req_wr) || $changed(req_sdram)));

  // R1: upper readback bits stay zero
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata >> CNT_W) == '0);

endmodule

// File: tb/bus_recov_gate_bench.sv
module bus_recov_gate_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_waddr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [1:0]  cfg_raddr = '0;
  logic [15:0] cfg_rdata;
  logic [3:0]  ch_en = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_ch = '0;
  logic        req_wr = 1'b0;
  logic        req_sdram = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_recov_gate u_bus_recov_gate (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata), .ch_en(ch_en),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_ch(req_ch), .req_wr(req_wr), .req_sdram(req_sdram)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] ch, input logic [15:0] d);
    cfg_we = 1'b1; cfg_waddr = ch; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic read_back(input logic [1:0] ch, output int v);
    cfg_raddr = ch;
    #1;
    v = int'(cfg_rdata);
  endtask

  // Entered at a falling edge; leaves at the falling edge after the grant
  task automatic do_acc(input logic [1:0] ch, input logic wr, input logic sd, output int w);
    req_ch = ch; req_wr = wr; req_sdram = sd; req_valid = 1'b1; w = 0;
    #1;
    while (!req_ready && w < 100) begin
      @(negedge clk); #1; w++;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pair(input logic [1:0] pch, input logic pwr, input logic psd, input int k,
                      input logic [1:0] nch, input logic nwr, input logic nsd,
                      input int need, input string tag);
    int w;
    int exp;
    do_acc(pch, pwr, psd, w);
    repeat (k) @(negedge clk);
    do_acc(nch, nwr, nsd, w);
    exp = (need > k) ? need - k : 0;
    chk($sformatf("%s%s N=%0d k=%0d", tag, (k > 0) ? " R9" : "", need, k), w, exp);
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    for (int c = 0; c < 4; c++) begin
      read_back(2'(c), v);
      chk($sformatf("R1 reset ch%0d", c), v, 0);
    end

    // R7: nothing granted since reset -> immediate grant
    do_acc(2'd1, 1'b0, 1'b0, w);
    chk("R7 first access R11", w, 0);

    // R2: open write, upper bits dropped
    cfg_write(2'd0, 16'hABC5);
    read_back(2'd0, v);
    chk("R2 open write R1", v, 5);

    // R3: enabled channel ignores write
    ch_en = 4'b0001;
    cfg_write(2'd0, 16'h000A);
    read_back(2'd0, v);
    chk("R3 locked write", v, 5);
    ch_en = 4'b0000;
    cfg_write(2'd0, 16'h000A);
    read_back(2'd0, v);
    chk("R2 reopened write", v, 10);

    // Sweep every count and idle gap over each access-pair case
    for (int n = 0; n < 16; n++) begin
      ch_en = 4'b0000;
      cfg_write(2'd1, 16'(n));
      cfg_write(2'd2, 16'(15 - n));
      ch_en = 4'b1111;
      for (int k = 0; k <= 16; k++) begin
        pair(2'd1, 1'b0, 1'b0, k, 2'd1, 1'b1, 1'b0, n, "R4 rd->wr same ch");
        pair(2'd1, 1'b0, 1'b0, k, 2'd2, 1'b0, 1'b0, n, "R5 R10 rd->rd other ch");
        pair(2'd1, 1'b0, 1'b0, k, 2'd1, 1'b0, 1'b0, 0, "R6 rd->rd same ch");
        pair(2'd1, 1'b1, 1'b0, k, 2'd2, 1'b0, 1'b0, 0, "R7 wr->rd");
        pair(2'd1, 1'b0, 1'b1, k, 2'd1, 1'b1, 1'b0, 0, "R8 sdram prev");
        pair(2'd1, 1'b0, 1'b0, k, 2'd2, 1'b0, 1'b1, 0, "R8 sdram next");
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule